// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte Selects, Bursts and Sleep

This block is a single-port synchronous memory with a shared data bus. The bus is modelled as a separate input word, output word and output-enable. A command is sampled on one rising edge: chip enable, write enable, burst advance, address and byte selects. For a write, the data word is taken from the bus on the following edge. On that edge the next command may already be issued, so reads and writes run back to back with no idle cycle. A read returns its word in the cycle after its command edge. If the read targets the word whose write data is being captured on that same edge, the newly written bytes are forwarded into the result.

A four-beat burst starts from one loaded address. It then steps through the two low address bits in either a linear (wrap-around add) order or an interleaved (XOR) order, chosen when the burst is loaded.

An asynchronous sleep request is synchronised and takes two edges to enter or leave the low-power state. While the block is asleep, and for a fixed recovery window after it wakes, every attempted command is dropped and flagged. The array contents are kept throughout.

Top module: `late_write_sram`

## Requirements
- R1: A write command sampled on edge N (cmd_en=1, cmd_adv=0, cmd_we=1) stores the dq_in word present on edge N+1 at the command's address.
- R2: A command may be issued on the edge that captures the previous write's data. A read of the same address on that edge returns the newly written bytes merged with the old ones.
- R3: byte_sel is sampled with the write command. Bit i enables bits [8i+7:8i] of the word, and bytes whose select is 0 keep their stored value.
- R4: In the cycle between a write command edge and its data capture edge, dq_oe is 0 whatever the value of oe.
- R5: A read command sampled on edge N drives its word on dq_out, with dq_oe equal to oe, during the cycle after edge N. While oe is 0, dq_oe is 0.
- R6: A burst is loaded by a read or write command with cmd_adv=0. Each later edge with cmd_adv=1 performs the next beat, ignoring cmd_en and cmd_we. Beat k of a burst loaded at address A reaches {A[5:2], off}. With lin_order=1, off = (A[1:0]+k) mod 4; with lin_order=0, off = A[1:0] XOR k. The order wraps after four beats.
- R7: Each write beat of a burst uses the byte_sel value sampled on that beat's edge.
- R8: sleep_state rises on the second rising edge after sleep_req goes high, and falls on the second rising edge after sleep_req goes low.
- R9: While sleep_state is 1, any edge with cmd_en=1 or cmd_adv=1 performs no access, and access_rejected is 1 in the following cycle. The stored contents survive the sleep period.
- R10: On the first RECOV_CYC (default 2) edges after sleep_state falls, commands are also rejected and flagged. The next command is accepted.
- R11: After reset, dq_oe, sleep_state and access_rejected are 0.
- R12: An edge with cmd_en=0 and cmd_adv=0 is a deselect and ends any burst. A later cmd_adv=1 with no active burst performs no access and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Chip enable for a new (load) command |
| cmd_we | input | 1 | 1 = write, 0 = read, sampled with a load |
| cmd_adv | input | 1 | 1 = advance the active burst, 0 = load or deselect |
| cmd_addr | input | AW (6) | Word address for a load |
| byte_sel | input | NB (2) | Per-byte write select, active high |
| lin_order | input | 1 | Burst order for a load: 1 linear, 0 interleaved |
| oe | input | 1 | Output enable request |
| sleep_req | input | 1 | Asynchronous sleep request |
| dq_in | input | NB*BW (16) | Write data, captured one edge after the command |
| dq_out | output | NB*BW (16) | Read data |
| dq_oe | output | 1 | Drive enable for dq_out |
| sleep_state | output | 1 | Synchronised sleep status |
| access_rejected | output | 1 | Pulse: previous edge's command was dropped |

## Verification
The checker watches several properties on every cycle. A data capture is always preceded by a write issue one edge earlier. The output drive stays off during every write data phase and whenever oe is low. The sleep status tracks the request with exactly two edges of lag. Every command seen while blocked, and the first one after wake-up, is flagged. Correct stored values are a different matter and only the bench's scenarios can show them. These cover the byte-select merge, forwarding on a back-to-back read, both burst orders from every start offset with wrap-around, per-beat selects in a burst write, and retention of contents across sleep.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Offset of a beat within a four-word group.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       linear);
    logic [1:0] r;
    if (linear) r = start + beat;
    else        r = start ^ beat;
    return r;
  endfunction

endpackage

// File: rtl/lw_sram_sleep.sv
module lw_sram_sleep #(
  parameter int RECOV_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep,
  output logic blocked
);
  localparam int CW = $clog2(RECOV_CYC + 2);

  logic          sync1;
  logic [CW-1:0] recov_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 1'b0;
      asleep    <= 1'b0;
      recov_cnt <= '0;
    end else begin
      sync1  <= sleep_req;
      asleep <= sync1;
      if (asleep)              recov_cnt <= CW'(RECOV_CYC);
      else if (recov_cnt != 0) recov_cnt <= recov_cnt - 1'b1;
    end
  end

  assign blocked = asleep | (recov_cnt != '0);

endmodule

// File: rtl/lw_sram_burst.sv
module lw_sram_burst
  import lw_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_en,
  input  logic          cmd_we,
  input  logic          cmd_adv,
  input  logic [AW-1:0] cmd_addr,
  input  logic          lin_order,
  input  logic          blocked,
  output logic          wr_issue,
  output logic          rd_issue,
  output logic [AW-1:0] eff_addr,
  output logic          reject
);
  logic          active, is_wr, lin_q;
  logic [AW-1:0] base;
  logic [1:0]    beat;

  logic          load, cont;
  logic [AW-1:0] base_sel;
  logic [1:0]    beat_sel;
  logic          lin_sel;

  always_comb begin
    load     = cmd_en & ~cmd_adv & ~blocked;
    cont     = cmd_adv & active & ~blocked;
    base_sel = load ? cmd_addr  : base;
    beat_sel = load ? 2'd0      : beat + 2'd1;
    lin_sel  = load ? lin_order : lin_q;
    eff_addr = {base_sel[AW-1:2], beat_offset(base_sel[1:0], beat_sel, lin_sel)};
    wr_issue = load ? cmd_we  : (cont & is_wr);
    rd_issue = load ? ~cmd_we : (cont & ~is_wr);
    reject   = blocked & (cmd_en | cmd_adv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      lin_q  <= 1'b0;
      base   <= '0;
      beat   <= '0;
    end else if (blocked) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      is_wr  <= cmd_we;
      lin_q  <= lin_order;
      base   <= cmd_addr;
      beat   <= 2'd0;
    end else if (cont) begin
      beat   <= beat + 2'd1;
    end else if (!cmd_adv) begin
      active <= 1'b0;
    end
  end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_issue,
  input  logic             rd_issue,
  input  logic [AW-1:0]    acc_addr,
  input  logic [NB-1:0]    wr_be,
  input  logic             commit_ok,
  input  logic [NB*BW-1:0] din,
  output logic             wr_phase,
  output logic             mem_we,
  output logic             rd_valid,
  output logic [NB*BW-1:0] rd_data
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          pend;
  logic [AW-1:0] p_addr;
  logic [NB-1:0] p_be;
  logic [NB-1:0] fwd_be;
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      pend     <= wr_issue;
      rd_valid <= rd_issue;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_issue) begin
      p_addr <= acc_addr;
      p_be   <= wr_be;
    end
  end

  assign wr_phase = pend;
  assign mem_we   = pend & commit_ok;
  assign fwd_be   = (mem_we && p_addr == acc_addr) ? p_be : '0;

  always_ff @(posedge clk) begin
    if (mem_we)
      for (int i = 0; i < NB; i++)
        if (p_be[i]) mem[p_addr][i*BW +: BW] <= din[i*BW +: BW];
  end

  always_comb begin
    rd_word = mem[acc_addr];
    for (int i = 0; i < NB; i++)
      if (fwd_be[i]) rd_word[i*BW +: BW] = din[i*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (rd_issue) rd_data <= rd_word;
  end

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram #(
  parameter int AW        = 6,
  parameter int NB        = 2,
  parameter int BW        = 8,
  parameter int RECOV_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_en,
  input  logic             cmd_we,
  input  logic             cmd_adv,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [NB-1:0]    byte_sel,
  input  logic             lin_order,
  input  logic             oe,
  input  logic             sleep_req,
  input  logic [NB*BW-1:0] dq_in,
  output logic [NB*BW-1:0] dq_out,
  output logic             dq_oe,
  output logic             sleep_state,
  output logic             access_rejected
);
  localparam int DW = NB * BW;

  logic          blocked;
  logic          wr_issue, rd_issue, reject;
  logic [AW-1:0] eff_addr;
  logic          wr_phase, mem_we, rd_valid;
  logic [DW-1:0] rd_data;

  lw_sram_sleep #(.RECOV_CYC(RECOV_CYC)) u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .asleep(sleep_state), .blocked(blocked)
  );

  lw_sram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_we(cmd_we),
    .cmd_adv(cmd_adv), .cmd_addr(cmd_addr), .lin_order(lin_order),
    .blocked(blocked), .wr_issue(wr_issue), .rd_issue(rd_issue),
    .eff_addr(eff_addr), .reject(reject)
  );

  lw_sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_issue(wr_issue), .rd_issue(rd_issue),
    .acc_addr(eff_addr), .wr_be(byte_sel), .commit_ok(~sleep_state),
    .din(dq_in), .wr_phase(wr_phase), .mem_we(mem_we),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) access_rejected <= 1'b0;
    else        access_rejected <= reject;
  end

  assign dq_out = rd_data;
  assign dq_oe  = rd_valid & oe & ~wr_phase;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_en,
  input logic cmd_adv,
  input logic oe,
  input logic sleep_req,
  input logic dq_oe,
  input logic sleep_state,
  input logic access_rejected,
  input logic wr_issue,
  input logic mem_we,
  input logic wr_phase,
  input logic blocked
);

  // R1: a capture only follows a write issue one edge earlier
  p_late_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_issue));

  // R4: no drive during the write data phase
  p_hiz_wr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |-> !dq_oe);

  // R5: output enable low keeps drivers off
  p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_oe);

  // R8: two-edge synchronisation of the sleep request
  p_sleep_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_state == $past(sleep_req, 2));

  // R9: commands while blocked are flagged
  p_flag_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && (cmd_en || cmd_adv)) |=> access_rejected);

  // R10: first command after wake-up still falls in recovery
  p_recovery_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep_state) && cmd_en) |=> access_rejected);

endmodule

bind late_write_sram lw_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_adv(cmd_adv), .oe(oe),
  .sleep_req(sleep_req), .dq_oe(dq_oe), .sleep_state(sleep_state),
  .access_rejected(access_rejected), .wr_issue(wr_issue), .mem_we(mem_we),
  .wr_phase(wr_phase), .blocked(blocked)
);

// File: tb/late_write_sram_tb.sv
module late_write_sram_tb;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int DW = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_en = 0, cmd_we = 0, cmd_adv = 0, lin_order = 0, oe = 1, sleep_req = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [NB-1:0] byte_sel = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe, sleep_state, access_rejected;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  late_write_sram #(.AW(AW), .NB(NB), .BW(BW), .RECOV_CYC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_we(cmd_we),
    .cmd_adv(cmd_adv), .cmd_addr(cmd_addr), .byte_sel(byte_sel),
    .lin_order(lin_order), .oe(oe), .sleep_req(sleep_req), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .sleep_state(sleep_state),
    .access_rejected(access_rejected)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 257) ^ 16'h5A3C);
  endfunction

  function automatic int order_off(input int s, input int k, input bit lin);
    if (lin) return (s + k) % 4;
    return s ^ (k % 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; return at the next falling edge.
  task automatic step(input bit en, input bit we, input bit adv, input int addr,
                      input int be, input bit lin, input logic [DW-1:0] d);
    cmd_en = en; cmd_we = we; cmd_adv = adv; cmd_addr = AW'(addr);
    byte_sel = NB'(be); lin_order = lin; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [DW-1:0] d);
    step(0, 0, 0, 0, 0, 0, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 dq_oe", dq_oe, 0);
    check("R11 sleep_state", sleep_state, 0);
    check("R11 access_rejected", access_rejected, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R4: back-to-back writes fill 0..15; data lags one cycle
    for (int a = 0; a < 16; a++) begin
      step(1, 1, 0, a, 3, 1, (a == 0) ? '0 : pat(a - 1));
      check("R4 hiz in write data phase", dq_oe, 0);
    end
    idle(pat(15));

    // R5: back-to-back reads return stored words
    for (int a = 0; a < 16; a++) begin
      step(1, 0, 0, a, 0, 1, '0);
      check("R5 dq_oe on read", dq_oe, 1);
      check("R1 read back", dq_out, pat(a));
    end
    oe = 0;
    step(1, 0, 0, 3, 0, 1, '0);
    check("R5 oe low", dq_oe, 0);
    oe = 1;
    idle('0);

    // R2/R3: byte-select sweep with forwarding on the capture edge
    for (int b = 0; b < 4; b++) begin
      logic [DW-1:0] e;
      e = ((b & 1) ? 16'h00EF : 16'h0000) | ((b & 2) ? 16'hBE00 : 16'h0000);
      step(1, 1, 0, 20, 3, 1, '0);
      step(1, 1, 0, 20, b, 1, '0);
      step(1, 0, 0, 20, 0, 1, 16'hBEEF);
      check("R2 forwarded read", dq_out, e);
      step(1, 0, 0, 20, 0, 1, '0);
      check("R3 byte merge", dq_out, e);
      idle('0);
    end

    // R6: burst reads, both orders, every start offset, plus wrap
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        step(1, 0, 0, 8 + s, 0, lin[0], '0);
        check("R6 burst beat0", dq_out, pat(8 + order_off(s, 0, lin[0])));
        for (int k = 1; k < 5; k++) begin
          step(1, 1, 1, 40, 3, ~lin[0], '0);
          check("R6 burst beat", dq_out, pat(8 + order_off(s, k, lin[0])));
          check("R6 burst drive", dq_oe, 1);
        end
        idle('0);
      end
    end

    // R7: burst write with a different byte_sel on each beat
    for (int a = 32; a < 36; a++) step(1, 1, 0, a, 3, 1, (a == 32) ? '0 : 16'h0000);
    idle('0);
    step(1, 1, 0, 34, 3, 1, '0);
    step(0, 0, 1, 0, 1, 1, 16'hC0C0);
    step(0, 0, 1, 0, 2, 1, 16'hC1C1);
    step(0, 0, 1, 0, 3, 1, 16'hC2C2);
    step(0, 0, 0, 0, 0, 1, 16'hC3C3);
    step(1, 0, 0, 34, 0, 1, '0);
    check("R7 beat0 full", dq_out, 16'hC0C0);
    step(1, 0, 0, 35, 0, 1, '0);
    check("R7 beat1 low byte", dq_out, 16'h00C1);
    step(1, 0, 0, 32, 0, 1, '0);
    check("R7 beat2 high byte", dq_out, 16'hC200);
    step(1, 0, 0, 33, 0, 1, '0);
    check("R7 beat3 full", dq_out, 16'hC3C3);
    idle('0);

    // R12: stray advance after deselect does nothing
    step(0, 1, 1, 7, 3, 1, '0);
    check("R12 stray adv no drive", dq_oe, 0);
    check("R12 stray adv no flag", access_rejected, 0);
    step(0, 0, 0, 0, 0, 1, 16'h1111);
    step(1, 0, 0, 35, 0, 1, '0);
    check("R12 no stray write", dq_out, 16'h00C1);
    idle('0);

    // R8/R9/R10: sleep entry, blocked accesses, wake and recovery
    sleep_req = 1;
    idle('0);
    check("R8 one edge not asleep", sleep_state, 0);
    idle('0);
    check("R8 asleep after two edges", sleep_state, 1);
    step(1, 0, 0, 5, 0, 1, '0);
    check("R9 read flagged", access_rejected, 1);
    check("R9 read not driven", dq_oe, 0);
    step(1, 1, 0, 5, 3, 1, '0);
    check("R9 write flagged", access_rejected, 1);
    idle(16'hDEAD);
    sleep_req = 0;
    idle('0);
    check("R8 still asleep one edge", sleep_state, 1);
    idle('0);
    check("R8 awake after two edges", sleep_state, 0);
    step(1, 0, 0, 5, 0, 1, '0);
    check("R10 recovery reject 1", access_rejected, 1);
    step(1, 0, 0, 5, 0, 1, '0);
    check("R10 recovery reject 2", access_rejected, 1);
    check("R10 recovery no drive", dq_oe, 0);
    step(1, 0, 0, 5, 0, 1, '0);
    check("R10 accepted after recovery", access_rejected, 0);
    check("R9 contents kept", dq_out, pat(5));
    check("R9 read driven", dq_oe, 1);
    idle('0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule